// File: doc/BRIEF.md
# Serial EEPROM Slave Controller

This block is the target side of a two-wire serial bus (clock line plus open-drain data line) that fronts a byte-wide non-volatile-style storage array. It watches the clock and data lines through synchronizers in the system clock domain and picks out start and stop conditions. It shifts in a control byte, checks it against a fixed prefix and three strap inputs, and then either takes a two-byte word address followed by write data, or shifts stored bytes out. It acknowledges by pulling the data line low through an output-enable.

Written bytes are first collected in a page buffer. A stop that follows at least one complete data byte moves the collected bytes into the array during a timed internal write cycle. While that cycle runs, the block ignores the bus entirely. A host reads a byte at an arbitrary address by loading the word address, then issuing a repeated start with the read bit set. While the host keeps acknowledging, the block keeps returning consecutive bytes.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset `sda_oe` is 0, and bytes clocked before any start condition are not acknowledged (a start is the data line falling while the clock is high; a stop is the data line rising while the clock is high).
- R2: The control byte is sent MSB first as bit7..bit4 = 1010, bit3..bit1 = `dev_sel[2:0]`, bit0 = direction (1 read, 0 write). On a match the block drives `sda_oe` high for the whole ninth clock, and `sda_oe` only changes while the clock is low.
- R3: A control byte with a wrong prefix or wrong strap bits is not acknowledged, and `sda_oe` stays 0 for every later clock until the next start.
- R4: A write sends two word-address bytes (high byte first), each of which is acknowledged. Only the low `ADDR_W` bits (10 by default) of the 16 received bits select the location; the higher bits have no effect.
- R5: Each received data byte is acknowledged, and a stop after at least one complete data byte stores the bytes so that they read back afterwards.
- R6: During a write, the low `PAGE_W` bits (6) of the address advance after each data byte and wrap within the same 64-byte page; the upper bits do not change.
- R7: For `WR_CYCLES` system clocks after a storing stop, the block does not acknowledge its control byte. Once that time has passed, a polling control byte is acknowledged.
- R8: After the word-address bytes, a repeated start with a read control byte is acknowledged, and the returned data comes from the loaded address.
- R9: While the host acknowledges each read byte with 0, the next byte follows from the next address. After the last location the address wraps to location 0.
- R10: A read that starts directly with a read control byte returns the byte one past the last location read.
- R11: A stop that arrives before any complete data byte starts no write cycle. The next control byte is acknowledged at once and the stored data is unchanged.
- R12: A stop or start that arrives after two or more clocks of an unfinished byte abandons the write: nothing is stored and no write cycle starts.
- R13: When the host leaves the ninth bit of a read byte high, the block releases the data line and sends nothing more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (as seen on the wire) |
| dev_sel | input | 3 | Strap bits matched against control-byte bits 3..1 |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |

## Verification
The assertions assume that the host changes the data line only while the clock is low, except for start and stop conditions. They also assume that every clock phase lasts well beyond the two-stage synchronizer latency, so that no edge is missed and start or stop detection never coincides with a clock edge. The bench drives the bus as a host with quarter-bit phases of several system clocks. It changes the data line one quarter-bit after the clock falls and never drives against the block during acknowledge or read-data bits.

// File: rtl/eep_pkg.sv
// Shared types for the serial EEPROM slave.
// Assumes: nothing beyond the standard types.
package eep_pkg;

    // Protocol engine states: receive phases, acknowledge phases, read phases
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK
    } eng_state_t;

    // Fixed upper nibble of the control byte
    localparam logic [3:0] CTRL_PREFIX = 4'b1010;

endpackage

// File: rtl/eep_bus_sampler.sv
// Bus sampler: synchronizes the two bus lines into clk and flags
// clock edges plus start/stop conditions, one clk cycle each.
// Assumes: every bus phase lasts several clk cycles; idle bus is high.
module eep_bus_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_q;
    logic                   sda_q;

    // Synchronizer chains plus one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_sync[SYNC_STAGES-1];
            sda_q    <= sda_sync[SYNC_STAGES-1];
        end
    end

    // Edge and condition decode from current and previous samples
    always_comb begin
        scl_lvl   = scl_sync[SYNC_STAGES-1];
        sda_lvl   = sda_sync[SYNC_STAGES-1];
        scl_rise  = scl_lvl & ~scl_q;
        scl_fall  = ~scl_lvl & scl_q;
        start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
        stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
    end

endmodule

// File: rtl/eep_page_buf.sv
// Page buffer: collects one page of write data with a valid bit per
// slot until the store module commits it.
// Assumes: clr and we never coincide (engine gates both).
module eep_page_buf #(
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [PAGE_W-1:0] wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic              rd_valid,
    output logic [7:0]        rd_data
);
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [7:0]            slot [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid;

    // Valid flags: cleared on a new transfer, set per written slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
        end else if (clr) begin
            valid <= '0;
        end else if (we) begin
            valid[wr_idx] <= 1'b1;
        end
    end

    // Slot data storage (a later byte to the same slot overwrites)
    always_ff @(posedge clk) begin
        if (we) begin
            slot[wr_idx] <= wr_data;
        end
    end

    // Read port used by the commit sequencer
    always_comb begin
        rd_valid = valid[rd_idx];
        rd_data  = slot[rd_idx];
    end

endmodule

// File: rtl/eep_store.sv
// Storage array with the timed write cycle: on commit_go it walks the
// page buffer, copies valid slots into the selected page, and holds
// busy for WR_CYCLES clocks.
// Assumes: WR_CYCLES >= 2**PAGE_W; commit_go only while not busy.
module eep_store #(
    parameter int ADDR_W    = 10,
    parameter int PAGE_W    = 6,
    parameter int WR_CYCLES = 2000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit_go,
    input  logic [ADDR_W-PAGE_W-1:0] commit_page,
    output logic [PAGE_W-1:0]        buf_idx,
    input  logic                     buf_valid,
    input  logic [7:0]               buf_data,
    output logic                     busy,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int CNT_W      = $clog2(WR_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST_TICK  = CNT_W'(WR_CYCLES - 1);
    localparam logic [CNT_W-1:0] PAGE_TICKS = CNT_W'(PAGE_BYTES);

    logic [7:0]               mem [DEPTH];
    logic [CNT_W-1:0]         tick;
    logic [ADDR_W-PAGE_W-1:0] page_q;
    logic                     mem_we;

    // Write-cycle timer and latched target page
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            tick   <= '0;
            page_q <= '0;
        end else if (commit_go && !busy) begin
            busy   <= 1'b1;
            tick   <= '0;
            page_q <= commit_page;
        end else if (busy) begin
            if (tick == LAST_TICK) begin
                busy <= 1'b0;
            end else begin
                tick <= tick + CNT_W'(1);
            end
        end
    end

    // Slot walk: one buffer slot per clock during the first page ticks
    always_comb begin
        buf_idx = tick[PAGE_W-1:0];
        mem_we  = busy && (tick < PAGE_TICKS) && buf_valid;
        rd_data = mem[rd_addr];
    end

    // Array write port (contents are not reset)
    always_ff @(posedge clk) begin
        if (mem_we) begin
            mem[{page_q, buf_idx}] <= buf_data;
        end
    end

    // R7
    commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_go |-> !busy);

endmodule

// File: rtl/eep_engine.sv
// Protocol engine: bit-level receive/transmit state machine. It
// matches the control byte, loads the word address, streams data to the
// page buffer or from the array, and drives the acknowledge/read bits.
// Assumes: sampler pulses are one clk wide; bus phases span many clks.
module eep_engine
    import eep_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_lvl,
    input  logic                     sda_lvl,
    input  logic                     scl_rise,
    input  logic                     scl_fall,
    input  logic                     start_det,
    input  logic                     stop_det,
    input  logic [2:0]               dev_sel,
    input  logic                     busy,
    input  logic [7:0]               rd_data,
    output logic [ADDR_W-1:0]        ptr,
    output logic                     sda_oe,
    output logic                     buf_we,
    output logic [PAGE_W-1:0]        buf_idx,
    output logic [7:0]               buf_wdata,
    output logic                     buf_clr,
    output logic                     commit_go,
    output logic [ADDR_W-PAGE_W-1:0] commit_page
);
    eng_state_t  state;
    logic [7:0]  sh;
    logic [2:0]  cnt;
    logic        full;
    logic        got_data;
    logic        rw;
    logic        host_ack;
    logic [7:0]  addr_hi;
    logic        bus_live;

    // Bus events are acted on only outside a write cycle and outside start/stop
    always_comb begin
        bus_live    = !busy && !start_det && !stop_det;
        buf_we      = bus_live && (state == ST_WDAT) && scl_fall && full;
        buf_idx     = ptr[PAGE_W-1:0];
        buf_wdata   = sh;
        buf_clr     = start_det && !busy;
        commit_go   = stop_det && !busy && got_data && (state == ST_WDAT)
                      && !full && (cnt < 3'd2);
        commit_page = ptr[ADDR_W-1:PAGE_W];
    end

    // Open-drain drive: low during acknowledge clocks and for read zeros
    always_comb begin
        case (state)
            ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK: sda_oe = 1'b1;
            ST_RDAT:                                         sda_oe = ~sh[7];
            default:                                         sda_oe = 1'b0;
        endcase
    end

    // Main sequencer: condition handling first, then per-state bit work
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sh       <= '0;
            cnt      <= '0;
            full     <= 1'b0;
            got_data <= 1'b0;
            rw       <= 1'b0;
            host_ack <= 1'b0;
            addr_hi  <= '0;
            ptr      <= '0;
        end else if (busy) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            full     <= 1'b0;
            got_data <= 1'b0;
        end else if (stop_det) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            full     <= 1'b0;
            got_data <= 1'b0;
        end else if (start_det) begin
            state    <= ST_DEV;
            cnt      <= '0;
            full     <= 1'b0;
            got_data <= 1'b0;
        end else begin
            case (state)
                ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                    if (scl_rise) begin
                        sh  <= {sh[6:0], sda_lvl};
                        cnt <= cnt + 3'd1;
                        if (cnt == 3'd7) full <= 1'b1;
                    end else if (scl_fall && full) begin
                        full <= 1'b0;
                        cnt  <= '0;
                        case (state)
                            ST_DEV: begin
                                if (sh[7:4] == CTRL_PREFIX && sh[3:1] == dev_sel) begin
                                    rw    <= sh[0];
                                    state <= ST_DEV_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            ST_AHI: begin
                                addr_hi <= sh;
                                state   <= ST_AHI_ACK;
                            end
                            ST_ALO: begin
                                ptr   <= ADDR_W'({addr_hi, sh});
                                state <= ST_ALO_ACK;
                            end
                            default: begin
                                got_data <= 1'b1;
                                ptr      <= {ptr[ADDR_W-1:PAGE_W],
                                             ptr[PAGE_W-1:0] + PAGE_W'(1)};
                                state    <= ST_WDAT_ACK;
                            end
                        endcase
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            sh    <= rd_data;
                            ptr   <= ptr + ADDR_W'(1);
                            state <= ST_RDAT;
                        end else begin
                            state <= ST_AHI;
                        end
                    end
                end
                ST_AHI_ACK:  if (scl_fall) state <= ST_ALO;
                ST_ALO_ACK:  if (scl_fall) state <= ST_WDAT;
                ST_WDAT_ACK: if (scl_fall) state <= ST_WDAT;
                ST_RDAT: begin
                    if (scl_fall) begin
                        sh  <= {sh[6:0], 1'b0};
                        cnt <= cnt + 3'd1;
                        if (cnt == 3'd7) state <= ST_RACK;
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        host_ack <= ~sda_lvl;
                    end else if (scl_fall) begin
                        if (host_ack) begin
                            sh    <= rd_data;
                            ptr   <= ptr + ADDR_W'(1);
                            cnt   <= '0;
                            state <= ST_RDAT;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_lvl);

    // R2
    oe_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    // R7
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

endmodule

// File: rtl/serial_eeprom_slave.sv
// Top level: two-wire serial EEPROM target. Wires the bus sampler,
// protocol engine, page buffer and timed storage array together.
// Assumes: ADDR_W <= 16, PAGE_W < ADDR_W, WR_CYCLES >= 2**PAGE_W.
module serial_eeprom_slave #(
    parameter int ADDR_W      = 10,
    parameter int PAGE_W      = 6,
    parameter int WR_CYCLES   = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] dev_sel,
    output logic       sda_oe
);
    logic                     scl_lvl, sda_lvl, scl_rise, scl_fall;
    logic                     start_det, stop_det;
    logic                     busy;
    logic [ADDR_W-1:0]        ptr;
    logic [7:0]               rd_data;
    logic                     buf_we, buf_clr, buf_valid;
    logic [PAGE_W-1:0]        buf_widx, buf_ridx;
    logic [7:0]               buf_wdata, buf_rdata;
    logic                     commit_go;
    logic [ADDR_W-PAGE_W-1:0] commit_page;

    eep_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    eep_engine #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .dev_sel(dev_sel), .busy(busy),
        .rd_data(rd_data), .ptr(ptr), .sda_oe(sda_oe), .buf_we(buf_we),
        .buf_idx(buf_widx), .buf_wdata(buf_wdata), .buf_clr(buf_clr),
        .commit_go(commit_go), .commit_page(commit_page)
    );

    eep_page_buf #(.PAGE_W(PAGE_W)) u_page_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we),
        .wr_idx(buf_widx), .wr_data(buf_wdata), .rd_idx(buf_ridx),
        .rd_valid(buf_valid), .rd_data(buf_rdata)
    );

    eep_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_store (
        .clk(clk), .rst_n(rst_n), .commit_go(commit_go),
        .commit_page(commit_page), .buf_idx(buf_ridx), .buf_valid(buf_valid),
        .buf_data(buf_rdata), .busy(busy), .rd_addr(ptr), .rd_data(rd_data)
    );

    // R7
    buf_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> !busy);

endmodule

// File: tb/test_serial_eeprom_slave.sv
// Directed bench: acts as bus host, one task per scenario.
module test_serial_eeprom_slave;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 8;
    localparam logic [2:0] SEL = 3'b101;
    localparam logic [7:0] CW  = {4'b1010, SEL, 1'b0};
    localparam logic [7:0] CR  = {4'b1010, SEL, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_line;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    assign sda_line = m_sda & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_eeprom_slave i_serial_eeprom_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .dev_sel(SEL), .sda_oe(sda_oe)
    );

    task automatic wq();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq(); wq();
    endtask

    task automatic clk_bit(input bit b, output bit s);
        m_sda = b; wq(); m_scl = 1'b1; wq(); s = sda_line; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
        clk_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit host_ack);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            v[i] = s;
        end
        clk_bit(!host_ack, s);
    endtask

    task automatic set_addr(input logic [15:0] a, output bit ok);
        bit a0, a1, a2;
        bus_start();
        send_byte(CW, a0);
        send_byte(a[15:8], a1);
        send_byte(a[7:0], a2);
        ok = a0 & a1 & a2;
    endtask

    task automatic wait_ready(output int tries);
        bit ack;
        tries = 0;
        do begin
            bus_start(); send_byte(CW, ack); bus_stop();
            tries++;
        end while (!ack && tries < 40);
        chk("R7 ready after write cycle", int'(ack), 1);
    endtask

    task automatic write_one(input logic [15:0] a, input logic [7:0] d);
        bit ok, ack;
        int tries;
        set_addr(a, ok);
        send_byte(d, ack);
        bus_stop();
        chk("R5 single write acks", int'(ok & ack), 1);
        wait_ready(tries);
    endtask

    task automatic read_at(input logic [15:0] a, input int n, output logic [7:0] d [4]);
        bit ok, ack;
        set_addr(a, ok);
        bus_start();
        send_byte(CR, ack);
        chk("R8 random read acks", int'(ok & ack), 1);
        for (int i = 0; i < n; i++) recv_byte(d[i], i != n - 1);
        bus_stop();
    endtask

    task automatic t_reset();
        bit ack;
        chk("R1 sda_oe after reset", int'(sda_oe), 0);
        m_scl = 1'b0; wq();
        send_byte(CW, ack);
        chk("R1 no ack without start", int'(ack), 0);
        bus_stop();
    endtask

    task automatic t_write_read();
        bit ok, ack, a1, a2, a3;
        int tries;
        logic [7:0] d [4];
        set_addr(16'h0123, ok);
        chk("R2 R4 control and address acks", int'(ok), 1);
        send_byte(8'hC3, a1); send_byte(8'h3C, a2); send_byte(8'h96, a3);
        chk("R5 data acks", int'(a1 & a2 & a3), 1);
        bus_stop();
        bus_start(); send_byte(CW, ack); bus_stop();
        chk("R7 no ack while busy", int'(ack), 0);
        wait_ready(tries);
        chk("R7 needed more than one poll", int'(tries > 1), 1);
        read_at(16'h0123, 3, d);
        chk("R8 first byte", int'(d[0]), 'hC3);
        chk("R9 second byte", int'(d[1]), 'h3C);
        chk("R9 third byte", int'(d[2]), 'h96);
    endtask

    task automatic t_page_wrap();
        bit ok, a1, a2, a3, a4;
        int tries;
        logic [7:0] d [4];
        set_addr(16'h00BE, ok);
        send_byte(8'h11, a1); send_byte(8'h22, a2);
        send_byte(8'h33, a3); send_byte(8'h44, a4);
        bus_stop();
        chk("R6 page write acks", int'(ok & a1 & a2 & a3 & a4), 1);
        wait_ready(tries);
        read_at(16'h0080, 2, d);
        chk("R6 wrapped to page start", int'(d[0]), 'h33);
        chk("R6 wrapped second", int'(d[1]), 'h44);
        read_at(16'h00BE, 2, d);
        chk("R6 page end bytes", int'({d[0], d[1]}), 'h1122);
    endtask

    task automatic t_current_read();
        bit ack;
        logic [7:0] d [4];
        logic [7:0] v;
        read_at(16'h0080, 1, d);
        bus_start();
        send_byte(CR, ack);
        recv_byte(v, 1'b0);
        chk("R13 released after host no-ack", int'(sda_oe), 0);
        bus_stop();
        chk("R10 current address ack", int'(ack), 1);
        chk("R10 current address data", int'(v), 'h44);
    endtask

    task automatic t_ignore_hi();
        logic [7:0] d [4];
        write_one(16'hFC10, 8'h5A);
        read_at(16'h0010, 1, d);
        chk("R4 upper address bits ignored", int'(d[0]), 'h5A);
    endtask

    task automatic t_array_roll();
        logic [7:0] d [4];
        bit s;
        write_one(16'h03FF, 8'hE1);
        write_one(16'h0000, 8'hE2);
        read_at(16'h03FF, 2, d);
        chk("R9 last location", int'(d[0]), 'hE1);
        chk("R9 rollover to zero", int'(d[1]), 'hE2);
        bus_start(); send_byte(CR, s);
        recv_byte(d[0], 1'b0);
        clk_bit(1'b1, s);
        chk("R13 no drive after no-ack", int'(s), 1);
        bus_stop();
    endtask

    task automatic t_mismatch();
        bit ack, ack2;
        bus_start();
        send_byte({4'b1010, SEL ^ 3'b001, 1'b0}, ack);
        send_byte(8'h00, ack2);
        bus_stop();
        chk("R3 wrong strap no ack", int'(ack), 0);
        chk("R3 released until start", int'(ack2), 0);
        bus_start();
        send_byte({4'b1011, SEL, 1'b0}, ack);
        bus_stop();
        chk("R3 wrong prefix no ack", int'(ack), 0);
    endtask

    task automatic t_no_data();
        bit ok, ack;
        logic [7:0] d [4];
        set_addr(16'h0010, ok);
        bus_stop();
        bus_start(); send_byte(CW, ack); bus_stop();
        chk("R11 no write cycle after address-only", int'(ack), 1);
        read_at(16'h0010, 1, d);
        chk("R11 data unchanged", int'(d[0]), 'h5A);
    endtask

    task automatic t_abort();
        bit ok, ack, s;
        logic [7:0] d [4];
        set_addr(16'h0010, ok);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
        bus_stop();
        bus_start(); send_byte(CW, ack); bus_stop();
        chk("R12 stop mid-byte no busy", int'(ack), 1);
        set_addr(16'h0010, ok);
        send_byte(8'h77, ack);
        for (int i = 0; i < 3; i++) clk_bit(1'b1, s);
        bus_start();
        send_byte(CW, ack);
        bus_stop();
        chk("R12 start mid-byte reaccepted", int'(ack), 1);
        bus_start(); send_byte(CW, ack); bus_stop();
        chk("R12 start mid-byte no busy", int'(ack), 1);
        read_at(16'h0010, 1, d);
        chk("R12 data unchanged", int'(d[0]), 'h5A);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_mismatch();
        t_write_read();
        t_page_wrap();
        t_current_read();
        t_ignore_hi();
        t_no_data();
        t_abort();
        t_array_roll();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule